// File: doc/BRIEF.md
# UART FIFO and Interrupt Controller

This block sits between a register bus and a neighbouring serial engine that already handles bit timing. It holds two 16-entry FIFOs. The receive FIFO is filled by the engine, one character per strobe, and each entry stores the byte together with break, parity-error and frame-error flags. Software drains it by reading the data register. The transmit FIFO is filled by software writes to the data register. The engine drains it by taking the head byte, which the block presents on its own port.

The fill levels of the two FIFOs, an idle timer on the receive side and a sticky overrun flag form five status conditions. Each condition has its own mask bit. The masked conditions are ORed into one registered interrupt line. Software can clear each FIFO at once through control bits that clear themselves. Software can also read back the transmit fill level, which tells it how many more bytes it may write.

Register map (word addresses): 0 data, 1 interrupt (status and mask), 2 control, 3 status. Read data appears on `bus_rdata` in the cycle after the read strobe.

Top module: `sio_fifo_irq`

## Requirements
- R1: After reset both FIFOs are empty and every mask bit is 0. `irq` is low, and reading the status register (address 3) returns 0. Reading the interrupt register returns status 0x18 in bits 12:8, because the transmit FIFO is empty and below its threshold, and mask 0 in bits 4:0. At reset both thresholds are DEPTH/2 and the timeout count is 1.
- R2: Reading address 0 pops the oldest receive entry. The read returns the byte in bits 7:0, the frame error in bit 8, the parity error in bit 9, break in bit 10 and a valid flag of 1 in bit 11. Entries come out in arrival order. A read of an empty receive FIFO returns 0 and pops nothing.
- R3: Writing address 0 pushes bits 7:0 into the transmit FIFO. `tx_avail` is high while that FIFO holds data, and `tx_data` shows its oldest byte. A `tx_pop` pulse removes that byte. The status register shows the receive not-empty flag in bit 0, the transmit fill level in bits 12:8 and the receive fill level in bits 20:16.
- R4: A receive push that arrives while the receive FIFO holds 16 entries is dropped and sets the overrun status (interrupt bit 8). The overrun status stays set while the FIFO is read out. Only a receive FIFO reset or a block reset clears it.
- R5: The receive-high status (interrupt bit 9) is 1 exactly when the receive fill level is strictly greater than the receive threshold, which is control bits 4:0.
- R6: The transmit-empty status (interrupt bit 11) is 1 when the transmit FIFO is empty. The transmit-low status (interrupt bit 12) is 1 exactly when the transmit fill level is strictly less than the transmit threshold, which is control bits 12:8.
- R7: The receive-timeout status (interrupt bit 10) becomes 1 once `char_tick` has pulsed as many times as the timeout count (control bits 19:16) while the receive FIFO is not empty. Any receive push or pop restarts the count, and an empty FIFO clears it. A count of 0 disables the timeout.
- R8: `irq` equals the OR of the status bits ANDed with the mask bits (interrupt register bits 4:0, same order as bits 12:8), one clock after they change. Writing 0 to the interrupt register masks every source.
- R9: Writing control bit 24 empties the receive FIFO and clears overrun. Writing control bit 25 empties the transmit FIFO. Either takes effect at the edge of that write, the other FIFO is unaffected, and both bits read back as 0.
- R10: A transmit write while the transmit FIFO holds 16 entries is discarded, and the fill level stays 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| rx_push | input | 1 | Serial engine delivers a received character |
| rx_data | input | 8 | Received byte |
| rx_brk | input | 1 | Break detected on this character |
| rx_par | input | 1 | Parity error on this character |
| rx_frm | input | 1 | Frame error on this character |
| tx_pop | input | 1 | Serial engine takes the head transmit byte |
| tx_data | output | 8 | Head of the transmit FIFO |
| tx_avail | output | 1 | Transmit FIFO not empty |
| char_tick | input | 1 | One pulse per character time |
| irq | output | 1 | Combined masked interrupt |

## Verification
A wrong pointer or count inside either FIFO shows up at the next read of the data register, which returns a byte out of order, or at the next `tx_pop`, where `tx_data` disagrees with the scoreboard. A wrong count also shows in the fill-level fields one cycle after the push or pop that corrupted it. A lost or early overrun, threshold or timeout condition appears in the interrupt register on the next read. `irq` follows it one clock later, so every condition is probed at its exact boundary: threshold equal versus one over or under, the sixteenth versus the seventeenth push, and the tick count one short versus exactly reached.

// File: rtl/sio_fifo_pkg.sv
package sio_fifo_pkg;

  localparam int SRC_N = 5;

  localparam int SRC_RXOVR = 0;
  localparam int SRC_RXHI  = 1;
  localparam int SRC_RXTMO = 2;
  localparam int SRC_TXEMP = 3;
  localparam int SRC_TXLO  = 4;

  localparam logic [1:0] ADR_DATA = 2'd0;
  localparam logic [1:0] ADR_IRQ  = 2'd1;
  localparam logic [1:0] ADR_CTRL = 2'd2;
  localparam logic [1:0] ADR_STAT = 2'd3;

  localparam int CTRL_RXCLR = 24;
  localparam int CTRL_TXCLR = 25;

  typedef struct packed {
    logic       brk;
    logic       par;
    logic       frm;
    logic [7:0] data;
  } rx_ent_t;

endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          drop
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == LW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign drop    = push && full && !do_pop;
  assign dout    = mem[rp];
  assign level   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LW'(DEPTH));

  assert_full_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> (level == LW'(DEPTH)));

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> empty);

endmodule

// File: rtl/sio_rx_timer.sv
module sio_rx_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt <= '0;
    else if (tick && (cnt != '1)) cnt <= cnt + 1'b1;
  end

  assign expired = (limit != '0) && (cnt >= limit);

  assert_idle_clears_R7: assert property (@(posedge clk) disable iff (rst)
    !run |=> !expired);

  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0));

endmodule

// File: rtl/sio_fifo_irq.sv
module sio_fifo_irq
  import sio_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TMO_W = 4,
  localparam int LW   = $clog2(DEPTH) + 1,
  localparam int EW   = $bits(rx_ent_t)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_push,
  input  logic [7:0]  rx_data,
  input  logic        rx_brk,
  input  logic        rx_par,
  input  logic        rx_frm,
  input  logic        tx_pop,
  output logic [7:0]  tx_data,
  output logic        tx_avail,
  input  logic        char_tick,
  output logic        irq
);

  logic             wr_data, wr_irq, wr_ctrl, rd_data;
  logic             rx_clr, tx_clr, rx_pop;
  logic [SRC_N-1:0] mask, stat;
  logic [LW-1:0]    rx_thr, tx_thr, rx_level, tx_level;
  logic [TMO_W-1:0] tmo;
  logic             rx_empty, rx_full, rx_drop, rx_over;
  logic             tx_empty, tx_full, tx_drop, tmo_exp;
  rx_ent_t          rx_in, rx_head;
  logic [31:0]      rd_word;
  logic             unused_wbits;

  assign unused_wbits = ^{bus_wdata, rx_full, tx_full, tx_drop};

  assign wr_data = bus_wr && (bus_addr == ADR_DATA);
  assign wr_irq  = bus_wr && (bus_addr == ADR_IRQ);
  assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
  assign rd_data = bus_rd && (bus_addr == ADR_DATA);
  assign rx_clr  = wr_ctrl && bus_wdata[CTRL_RXCLR];
  assign tx_clr  = wr_ctrl && bus_wdata[CTRL_TXCLR];
  assign rx_pop  = rd_data && !rx_empty;

  assign rx_in = '{brk: rx_brk, par: rx_par, frm: rx_frm, data: rx_data};

  sio_fifo #(.W(EW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .push(rx_push), .din(rx_in), .pop(rx_pop), .dout(rx_head),
    .level(rx_level), .empty(rx_empty), .full(rx_full), .drop(rx_drop)
  );

  sio_fifo #(.W(8), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst(rst), .clr(tx_clr),
    .push(wr_data), .din(bus_wdata[7:0]), .pop(tx_pop), .dout(tx_data),
    .level(tx_level), .empty(tx_empty), .full(tx_full), .drop(tx_drop)
  );

  sio_rx_timer #(.CW(TMO_W)) u_rx_timer (
    .clk(clk), .rst(rst),
    .restart(rx_push || rx_pop || rx_clr),
    .run(!rx_empty), .tick(char_tick), .limit(tmo), .expired(tmo_exp)
  );

  assign tx_avail = !tx_empty;

  // sticky overrun: set by a dropped push, cleared only by the FIFO reset
  always_ff @(posedge clk) begin
    if (rst || rx_clr) rx_over <= 1'b0;
    else if (rx_drop)  rx_over <= 1'b1;
  end

  always_comb begin
    stat            = '0;
    stat[SRC_RXOVR] = rx_over;
    stat[SRC_RXHI]  = rx_level > rx_thr;
    stat[SRC_RXTMO] = tmo_exp;
    stat[SRC_TXEMP] = tx_empty;
    stat[SRC_TXLO]  = tx_level < tx_thr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask   <= '0;
      rx_thr <= LW'(DEPTH / 2);
      tx_thr <= LW'(DEPTH / 2);
      tmo    <= TMO_W'(1);
    end else begin
      if (wr_irq) mask <= bus_wdata[SRC_N-1:0];
      if (wr_ctrl) begin
        rx_thr <= bus_wdata[0 +: LW];
        tx_thr <= bus_wdata[8 +: LW];
        tmo    <= bus_wdata[16 +: TMO_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat & mask);
  end

  always_comb begin
    rd_word = '0;
    case (bus_addr)
      ADR_DATA: if (!rx_empty) rd_word[EW:0] = {1'b1, rx_head};
      ADR_IRQ: begin
        rd_word[SRC_N-1:0]  = mask;
        rd_word[8 +: SRC_N] = stat;
      end
      ADR_CTRL: begin
        rd_word[0 +: LW]     = rx_thr;
        rd_word[8 +: LW]     = tx_thr;
        rd_word[16 +: TMO_W] = tmo;
      end
      default: begin
        rd_word[0]       = !rx_empty;
        rd_word[8 +: LW] = tx_level;
        rd_word[16 +: LW] = rx_level;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_over && !rx_clr) |=> rx_over);

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (rst)
    (|(stat & mask)) |=> irq);

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq);

  assert_pop_valid_R2: assert property (@(posedge clk) disable iff (rst)
    rx_pop |=> bus_rdata[EW]);

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (rst)
    rx_clr |=> (rx_level == '0 && !rx_over));

endmodule

// File: tb/sio_fifo_irq_bench.sv
module sio_fifo_irq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        rx_push = 0, rx_brk = 0, rx_par = 0, rx_frm = 0;
  logic [7:0]  rx_data = 0;
  logic        tx_pop = 0;
  logic [7:0]  tx_data;
  logic        tx_avail;
  logic        char_tick = 0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_rx[$];
  logic [7:0]  exp_tx[$];
  logic [31:0] rd;

  always #10 clk = ~clk;

  sio_fifo_irq u_sio_fifo_irq (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_push(rx_push), .rx_data(rx_data), .rx_brk(rx_brk),
    .rx_par(rx_par), .rx_frm(rx_frm), .tx_pop(tx_pop),
    .tx_data(tx_data), .tx_avail(tx_avail), .char_tick(char_tick),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bread(input logic [1:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  // driver: pushes a character and records what the bus must return
  task automatic rx_put(input logic [7:0] b, input logic brk, input logic par, input logic frm);
    rx_push = 1; rx_data = b; rx_brk = brk; rx_par = par; rx_frm = frm;
    @(negedge clk);
    rx_push = 0;
    if (exp_rx.size() < 16) exp_rx.push_back({20'd0, 1'b1, brk, par, frm, b});
  endtask

  task automatic tx_put(input logic [7:0] b);
    bwrite(2'd0, {24'd0, b});
    if (exp_tx.size() < 16) exp_tx.push_back(b);
  endtask

  // monitor side for receive: reads the bus and compares in order
  task automatic drain_rx(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      bread(2'd0, rd);
      chk(req, rd, exp_rx.pop_front());
    end
  endtask

  task automatic tick();
    char_tick = 1;
    @(negedge clk);
    char_tick = 0;
  endtask

  task automatic take_tx();
    tx_pop = 1;
    @(negedge clk);
    tx_pop = 0;
  endtask

  // transmit monitor: compares the head byte at each accepted pop (R3)
  always @(posedge clk) begin
    if (!rst && tx_pop && tx_avail) begin
      if (exp_tx.size() == 0) chk("R3 unexpected tx byte", {24'd0, tx_data}, 32'hxxxx_xxxx);
      else chk("R3 tx order", {24'd0, tx_data}, {24'd0, exp_tx.pop_front()});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq low", {31'd0, irq}, 32'd0);
    bread(2'd3, rd); chk("R1 status reg", rd, 32'h0);
    bread(2'd1, rd); chk("R1 irq reg", rd, 32'h1800);
    bread(2'd2, rd); chk("R1 ctrl defaults", rd, 32'h0001_0808);

    // R2 entry fields and order, mixed flags
    rx_put(8'h41, 0, 0, 0);
    rx_put(8'h5A, 1, 0, 0);
    rx_put(8'h00, 0, 1, 1);
    rx_put(8'hFF, 1, 1, 0);
    bread(2'd3, rd); chk("R3 rx level in status", rd, 32'h0004_0001);
    drain_rx(4, "R2 rx entry");
    bread(2'd0, rd); chk("R2 empty read", rd, 32'h0);

    // R5 threshold boundary, timeout off
    bwrite(2'd2, 32'h0000_0802);
    rx_put(8'h11, 0, 0, 0);
    rx_put(8'h22, 0, 0, 0);
    bread(2'd1, rd); chk("R5 level equal to thr", rd, 32'h1800);
    rx_put(8'h33, 0, 0, 0);
    bread(2'd1, rd); chk("R5 level above thr", rd, 32'h1A00);

    // R8 mask and combine
    bwrite(2'd1, 32'h2);
    @(negedge clk);
    chk("R8 irq raised", {31'd0, irq}, 32'd1);
    bwrite(2'd1, 32'h0);
    @(negedge clk);
    chk("R8 zero write masks all", {31'd0, irq}, 32'd0);
    bwrite(2'd1, 32'h8);
    @(negedge clk);
    chk("R8 tx empty source", {31'd0, irq}, 32'd1);
    bwrite(2'd1, 32'h0);
    drain_rx(3, "R2 rx after threshold");

    // R7 timeout of 2 character times
    bwrite(2'd2, 32'h0002_080F);
    rx_put(8'h77, 0, 0, 0);
    tick();
    bread(2'd1, rd); chk("R7 one tick short", rd, 32'h1800);
    tick();
    bread(2'd1, rd); chk("R7 count reached", rd, 32'h1C00);
    rx_put(8'h78, 0, 0, 0);
    bread(2'd1, rd); chk("R7 push restarts", rd, 32'h1800);
    tick(); tick();
    bread(2'd1, rd); chk("R7 fires again", rd, 32'h1C00);
    drain_rx(1, "R7 pop");
    bread(2'd1, rd); chk("R7 pop restarts", rd, 32'h1800);
    drain_rx(1, "R7 pop");
    bwrite(2'd2, 32'h0000_080F);
    rx_put(8'h79, 0, 0, 0);
    tick(); tick(); tick();
    bread(2'd1, rd); chk("R7 zero count disables", rd, 32'h1800);
    drain_rx(1, "R7 pop");

    // R4 overrun
    for (int i = 0; i < 17; i++) rx_put(8'(i + 8'h80), i[0], i[1], i[2]);
    bread(2'd1, rd); chk("R4 overrun set", rd, 32'h1B00);
    drain_rx(16, "R4 kept entries");
    bread(2'd1, rd); chk("R4 overrun sticky", rd, 32'h1900);
    bread(2'd0, rd); chk("R2 empty after drain", rd, 32'h0);
    bwrite(2'd2, 32'h0100_080F);
    bread(2'd1, rd); chk("R4 cleared by rx reset", rd, 32'h1800);

    // R3 R6 R10 transmit path
    tx_put(8'hA1); tx_put(8'hA2); tx_put(8'hA3);
    chk("R3 tx avail", {31'd0, tx_avail}, 32'd1);
    bread(2'd3, rd); chk("R3 tx level", rd, 32'h0000_0300);
    bread(2'd1, rd); chk("R6 not empty but low", rd, 32'h1000);
    for (int i = 0; i < 13; i++) tx_put(8'(8'hB0 + i));
    bread(2'd3, rd); chk("R3 tx full level", rd, 32'h0000_1000);
    bread(2'd1, rd); chk("R6 full", rd, 32'h0000);
    tx_put(8'hEE);
    bread(2'd3, rd); chk("R10 write when full dropped", rd, 32'h0000_1000);
    for (int i = 0; i < 8; i++) take_tx();
    bread(2'd1, rd); chk("R6 level equal to thr", rd, 32'h0000);
    take_tx();
    bread(2'd1, rd); chk("R6 level below thr", rd, 32'h1000);
    for (int i = 0; i < 7; i++) take_tx();
    chk("R3 tx drained", {31'd0, tx_avail}, 32'd0);
    chk("R3 scoreboard empty", exp_tx.size(), 32'd0);
    bread(2'd1, rd); chk("R6 empty", rd, 32'h1800);

    // R9 independent FIFO resets
    tx_put(8'hC1); tx_put(8'hC2);
    rx_put(8'hD1, 0, 0, 0); rx_put(8'hD2, 0, 0, 0);
    bwrite(2'd2, 32'h0200_080F);
    exp_tx.delete();
    bread(2'd3, rd); chk("R9 tx reset only", rd, 32'h0002_0001);
    bread(2'd2, rd); chk("R9 reset bits read 0", rd, 32'h0000_080F);
    bwrite(2'd2, 32'h0100_080F);
    exp_rx.delete();
    bread(2'd3, rd); chk("R9 rx reset", rd, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule